// File: doc/BRIEF.md
# Fixed Off-Time Winding Current Chopper

This block regulates the current in one motor winding by switching a full bridge. Each regulation cycle starts with an on-phase, in which the bridge drives the winding with the polarity chosen by the `phase` input. A sense comparator outside the block raises `trip` once the winding current reaches its target. The block then holds the bridge in a decay state for a fixed number of clock cycles and turns the bridge on again. The on-time follows from the load, while the off-time stays constant. A blanking window after every turn-on masks `trip`, so the switching spike at turn-on cannot end the on-phase early.

There are three decay styles. Slow decay closes both low-side switches, so the winding current circulates through them. Fast decay drives the bridge in reverse, so the opposite switches carry the freewheeling current instead of the body diodes. Mixed decay runs fast decay for a programmable number of cycles and then slow decay for the rest of the off-time. Each leg has its own dead-time stage. No leg ever closes its high and low switches together, and both switches of a leg stay open for a programmable gap whenever the leg changes side. All timing inputs are counts of clock cycles and should only be changed while `en` is low.

Top module: `offtime_chopper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four gate outputs are low after that edge, and the controller is idle.
- R2: With `phase`=0 the on-phase closes the A-high and B-low switches (gates {ah,al,bh,bl} = 1001). With `phase`=1 it closes B-high and A-low (0110). The polarity is captured when an on-phase begins.
- R3: For `blank_cycles` edges after an on-phase begins, `trip` is ignored. With `trip` held high, the A-high gate is on for `blank_cycles`−`dead_cycles` cycles per cycle, and it rises every `blank_cycles`+1+`off_cycles` cycles.
- R4: Once a trip is accepted, the decay lasts `off_cycles` cycles (a value of 0 acts as 1). The on-phase gate pattern is restored exactly `off_cycles`+`dead_cycles`+2 edges after the edge that accepted the trip.
- R5: `decay_mode` 2'b00, and the otherwise unused code 2'b11, select slow decay: both low switches are closed (0101).
- R6: `decay_mode` 2'b01 selects fast decay for the whole off-time: the switches opposite to the drive are closed (0110 after polarity 0, 1001 after polarity 1).
- R7: `decay_mode` 2'b10 selects mixed decay: fast decay for `fast_cycles` cycles, then slow decay. A `fast_cycles` of 0 gives slow decay only. A value at or above `off_cycles` is clamped to it, so the whole off-time is fast.
- R8: The high and low switch of the same leg are never on at the same time.
- R9: When a leg changes side, both of its switches are low for `dead_cycles`+1 cycles: the old switch opens one edge after the new target appears, and the new switch closes `dead_cycles`+1 edges later.
- R10: A change of `phase` during an on-phase has no effect until the next on-phase. A change during the off-time restarts the full off-time from the edge that sees the change.
- R11: One edge after `en` is sampled low, all four gates are low and the controller is idle. After `en` returns high, a fresh on-phase with a full blanking window begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Enables the chopper; low forces all gates off |
| phase | input | 1 | Drive polarity (0: current A to B, 1: B to A) |
| trip | input | 1 | Comparator output, high when current reached target |
| decay_mode | input | 2 | 00 slow, 01 fast, 10 mixed, 11 slow |
| off_cycles | input | CNT_W (12) | Off-time length in clock cycles |
| blank_cycles | input | CNT_W (12) | Blanking window after turn-on in cycles |
| fast_cycles | input | CNT_W (12) | Fast-decay share of the off-time in mixed mode |
| dead_cycles | input | DEAD_W (4) | Dead-time count between switches of one leg |
| gate_ah | output | 1 | Leg A high-side switch command |
| gate_al | output | 1 | Leg A low-side switch command |
| gate_bh | output | 1 | Leg B high-side switch command |
| gate_bl | output | 1 | Leg B low-side switch command |

## Verification
The hardest case to reach from the ports is a polarity change that lands inside an off-time. It must restart the decay without disturbing the switching legs, and it can only be seen once the delayed on-phase finally appears. The stimulus accepts a trip at a known edge and toggles `phase` a fixed number of edges later. It then samples the gates at the exact edges where an unrestarted off-time would already have ended and where the restarted one ends, with the new polarity on one side of the dead-time gap. The dead-time gap itself is caught at the edge where the switching leg has opened its old switch but not yet closed the new one. Mixed decay with a zero count and with a count above the off-time is run alongside the other modes.

// File: rtl/chop_pkg.sv
// Shared definitions for the off-time current chopper.
// Assumes: decay mode codes are fixed by the block's port contract.
package chop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_FAST = 2'd2,
        ST_SLOW = 2'd3
    } chop_state_t;

    localparam logic [1:0] DECAY_SLOW  = 2'b00;
    localparam logic [1:0] DECAY_FAST  = 2'b01;
    localparam logic [1:0] DECAY_MIXED = 2'b10;

endpackage

// File: rtl/chop_leg.sv
// One half-bridge leg with dead-time insertion.
// Takes the requested side (high or low) and produces the two gate commands.
// On a side change, both gates drop for one edge, then wait dead_cycles more
// edges before the new side closes. Assumes dead_cycles only changes while en is low.
module chop_leg #(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              want_hi,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              gate_hi,
    output logic              gate_lo
);

    logic [DEAD_W-1:0] dcnt;
    logic [DEAD_W:0]   low_run;
    logic              last_lo;
    logic              last_hi;

    localparam logic [DEAD_W-1:0] DONE = '0;
    localparam logic [DEAD_W-1:0] STEP = 1;

    // Gate sequencing: hold, open both, count the gap, then close the requested side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
            dcnt    <= DONE;
        end else if (!en) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
            dcnt    <= dead_cycles;
        end else if ((gate_hi && want_hi) || (gate_lo && !want_hi)) begin
            dcnt    <= dcnt;
        end else if (gate_hi || gate_lo) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
            dcnt    <= dead_cycles;
        end else if (dcnt != DONE) begin
            dcnt    <= dcnt - STEP;
        end else begin
            gate_hi <= want_hi;
            gate_lo <= !want_hi;
        end
    end

    // Checker state: length of the current both-open run and the last closed side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
            last_lo <= 1'b0;
            last_hi <= 1'b0;
        end else begin
            if (gate_hi || gate_lo)
                low_run <= '0;
            else if (low_run != '1)
                low_run <= low_run + 1'b1;
            if (gate_lo) begin
                last_lo <= 1'b1;
                last_hi <= 1'b0;
            end else if (gate_hi) begin
                last_lo <= 1'b0;
                last_hi <= 1'b1;
            end
        end
    end

    assert_no_shoot_through_R8: assert property (
        @(posedge clk) disable iff (!rst_n) !(gate_hi && gate_lo));

    assert_dead_before_hi_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (gate_hi && !$past(gate_hi) && last_lo) |-> (low_run > {1'b0, dead_cycles}));

    assert_dead_before_lo_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (gate_lo && !$past(gate_lo) && last_hi) |-> (low_run > {1'b0, dead_cycles}));

    assert_gates_drop_R11: assert property (
        @(posedge clk) disable iff (!rst_n) !en |=> (!gate_hi && !gate_lo));

endmodule

// File: rtl/chop_fsm.sv
// Regulation state machine for the fixed off-time chopper.
// Runs on-phase (with blanking), then fast and/or slow decay for a fixed count,
// and requests a side per leg (index 0 = leg A, 1 = leg B).
// Assumes: trip is already synchronous to clk, and counts change only while en is low.
module chop_fsm
    import chop_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             phase,
    input  logic             trip,
    input  logic [1:0]       decay_mode,
    input  logic [CNT_W-1:0] off_cycles,
    input  logic [CNT_W-1:0] blank_cycles,
    input  logic [CNT_W-1:0] fast_cycles,
    output logic [1:0]       want_hi
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = 1;

    chop_state_t      state;
    chop_state_t      first_off;
    logic             pol;
    logic             phase_q;
    logic [CNT_W-1:0] bcnt;
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] frem;
    logic [CNT_W-1:0] off_len;
    logic [CNT_W-1:0] fast_eff;
    logic [CNT_W-1:0] frem_load;

    // Off-time setup: clamp the fast share and pick the first decay state.
    always_comb begin
        off_len  = (off_cycles == ZERO) ? ONE : off_cycles;
        fast_eff = (fast_cycles > off_len) ? off_len : fast_cycles;
        case (decay_mode)
            DECAY_FAST:  frem_load = off_len;
            DECAY_MIXED: frem_load = fast_eff;
            default:     frem_load = ZERO;
        endcase
        first_off = (frem_load != ZERO) ? ST_FAST : ST_SLOW;
    end

    // Sequencing of on-phase, blanking, decay and polarity restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pol     <= 1'b0;
            phase_q <= 1'b0;
            bcnt    <= ZERO;
            rem     <= ZERO;
            frem    <= ZERO;
        end else begin
            phase_q <= phase;
            if (!en) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        state <= ST_ON;
                        pol   <= phase;
                        bcnt  <= blank_cycles;
                    end
                    ST_ON: begin
                        if (bcnt != ZERO) begin
                            bcnt <= bcnt - ONE;
                        end else if (trip) begin
                            state <= first_off;
                            rem   <= off_len;
                            frem  <= frem_load;
                        end
                    end
                    default: begin
                        if (phase != phase_q) begin
                            state <= first_off;
                            rem   <= off_len;
                            frem  <= frem_load;
                        end else if (rem <= ONE) begin
                            state <= ST_ON;
                            pol   <= phase;
                            bcnt  <= blank_cycles;
                        end else begin
                            rem <= rem - ONE;
                            if (state == ST_FAST) begin
                                if (frem <= ONE)
                                    state <= ST_SLOW;
                                frem <= frem - ONE;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // Side request per leg from state and captured polarity.
    always_comb begin
        case (state)
            ST_ON:   want_hi = {pol, !pol};
            ST_FAST: want_hi = {!pol, pol};
            default: want_hi = 2'b00;
        endcase
    end

    assert_idle_when_disabled_R11: assert property (
        @(posedge clk) disable iff (!rst_n) !en |=> (state == ST_IDLE));

    assert_blank_holds_on_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_ON && bcnt != ZERO) |=> (state == ST_ON || state == ST_IDLE));

    assert_slow_never_back_to_fast_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_SLOW && phase == phase_q) |=> (state != ST_FAST));

endmodule

// File: rtl/offtime_chopper.sv
// Top of the fixed off-time winding current chopper.
// Combines the regulation state machine with two dead-time legs.
// Assumes an external comparator drives trip synchronously and the power stage
// maps gate_* one-to-one onto the bridge switches.
module offtime_chopper #(
    parameter int CNT_W  = 12,
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              phase,
    input  logic              trip,
    input  logic [1:0]        decay_mode,
    input  logic [CNT_W-1:0]  off_cycles,
    input  logic [CNT_W-1:0]  blank_cycles,
    input  logic [CNT_W-1:0]  fast_cycles,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              gate_ah,
    output logic              gate_al,
    output logic              gate_bh,
    output logic              gate_bl
);

    localparam int LEGS = 2;

    logic [LEGS-1:0] want_hi;
    logic [LEGS-1:0] hi;
    logic [LEGS-1:0] lo;

    chop_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .phase        (phase),
        .trip         (trip),
        .decay_mode   (decay_mode),
        .off_cycles   (off_cycles),
        .blank_cycles (blank_cycles),
        .fast_cycles  (fast_cycles),
        .want_hi      (want_hi)
    );

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        chop_leg #(.DEAD_W(DEAD_W)) u_leg (
            .clk         (clk),
            .rst_n       (rst_n),
            .en          (en),
            .want_hi     (want_hi[g]),
            .dead_cycles (dead_cycles),
            .gate_hi     (hi[g]),
            .gate_lo     (lo[g])
        );
    end

    assign gate_ah = hi[0];
    assign gate_al = lo[0];
    assign gate_bh = hi[1];
    assign gate_bl = lo[1];

endmodule

// File: tb/test_offtime_chopper.sv
module test_offtime_chopper;

    localparam int CNT_W  = 12;
    localparam int DEAD_W = 4;
    localparam int OFF    = 20;
    localparam int BLANK  = 8;
    localparam int DEAD   = 2;
    localparam int NV     = 9;

    // {mode[1:0], phase, fast[7:0], drive, early decay, late decay, gap} ; gates {ah,al,bh,bl}
    localparam logic [26:0] VEC [NV] = '{
        {2'b00, 1'b0, 8'd6,  4'b1001, 4'b0101, 4'b0101, 4'b0001},
        {2'b00, 1'b1, 8'd6,  4'b0110, 4'b0101, 4'b0101, 4'b0100},
        {2'b01, 1'b0, 8'd6,  4'b1001, 4'b0110, 4'b0110, 4'b0000},
        {2'b01, 1'b1, 8'd6,  4'b0110, 4'b1001, 4'b1001, 4'b0000},
        {2'b10, 1'b0, 8'd6,  4'b1001, 4'b0110, 4'b0101, 4'b0001},
        {2'b10, 1'b1, 8'd6,  4'b0110, 4'b1001, 4'b0101, 4'b0100},
        {2'b10, 1'b0, 8'd0,  4'b1001, 4'b0101, 4'b0101, 4'b0001},
        {2'b10, 1'b0, 8'd50, 4'b1001, 4'b0110, 4'b0110, 4'b0000},
        {2'b11, 1'b1, 8'd6,  4'b0110, 4'b0101, 4'b0101, 4'b0100}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              phase = 1'b0;
    logic              trip = 1'b0;
    logic [1:0]        decay_mode = 2'b00;
    logic [CNT_W-1:0]  off_cycles = CNT_W'(OFF);
    logic [CNT_W-1:0]  blank_cycles = CNT_W'(BLANK);
    logic [CNT_W-1:0]  fast_cycles = '0;
    logic [DEAD_W-1:0] dead_cycles = DEAD_W'(DEAD);
    logic              gate_ah, gate_al, gate_bh, gate_bl;
    logic [3:0]        g;
    logic [26:0]       v;
    int                checks = 0;
    int                failures = 0;
    int                n;
    logic              overlap_seen = 1'b0;

    always #2 clk = ~clk;

    assign g = {gate_ah, gate_al, gate_bh, gate_bl};

    offtime_chopper #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) i_offtime_chopper (
        .clk(clk), .rst_n(rst_n), .en(en), .phase(phase), .trip(trip),
        .decay_mode(decay_mode), .off_cycles(off_cycles), .blank_cycles(blank_cycles),
        .fast_cycles(fast_cycles), .dead_cycles(dead_cycles),
        .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl)
    );

    always @(negedge clk)
        if ((gate_ah && gate_al) || (gate_bh && gate_bl)) overlap_seen = 1'b1;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0d (%b) exp=%0d (%b)", what, act, act[3:0], exp, exp[3:0]);
        end
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    // Raise trip for exactly the edge T; returns just after T.
    task automatic pulse_trip();
        @(negedge clk) trip = 1'b1;
        @(posedge clk);
        #1 trip = 1'b0;
    endtask

    task automatic wait_rise_ah();
        logic prev;
        prev = gate_ah;
        do begin
            prev = gate_ah;
            edges(1);
        end while (!(gate_ah && !prev));
    endtask

    function automatic string mtag(input logic [1:0] m);
        case (m)
            2'b01:   return "R6 fast";
            2'b10:   return "R7 mixed";
            default: return "R5 slow";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset forces gates low even with en high
        en = 1'b1;
        edges(3);
        chk("R1 gates during reset", g, 4'b0000);
        @(negedge clk) en = 1'b0;
        rst_n = 1'b1;
        edges(3);
        chk("R1 gates idle after reset", g, 4'b0000);

        // Table: drive, dead gap, decay style, off-time, restore
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            @(negedge clk) en = 1'b0;
            decay_mode  = v[26:25];
            phase       = v[24];
            fast_cycles = CNT_W'(v[23:16]);
            edges(2);
            @(negedge clk) en = 1'b1;
            edges(20);
            chk("R2 drive pattern", g, v[15:12]);
            pulse_trip();                        // edge T
            edges(1);
            chk("R9 old switch opened", g, v[15:12] & v[11:8]);
            edges(DEAD);
            chk("R9 gap still open", g, v[15:12] & v[11:8]);
            edges(1);
            chk({mtag(v[26:25]), " first decay"}, g, v[11:8]);
            edges(OFF - 2 - DEAD);
            chk({mtag(v[26:25]), " late decay"}, g, v[7:4]);
            edges(1 + DEAD);
            chk("R4 R9 restore gap", g, v[3:0]);
            edges(1);
            chk("R4 drive restored", g, v[15:12]);
        end

        // R10: polarity change while on, then during off-time
        @(negedge clk) en = 1'b0;
        decay_mode  = 2'b00;
        phase       = 1'b0;
        fast_cycles = '0;
        edges(2);
        @(negedge clk) en = 1'b1;
        edges(20);
        chk("R2 phase0 drive", g, 4'b1001);
        @(negedge clk) phase = 1'b1;
        edges(10);
        chk("R10 on-phase keeps old polarity", g, 4'b1001);
        pulse_trip();
        edges(24);
        chk("R10 new polarity at next on-phase", g, 4'b0110);
        edges(20);
        pulse_trip();                            // edge T'
        edges(4);
        @(negedge clk) phase = 1'b0;             // seen at T'+5
        edges(20);                               // T'+24
        chk("R10 off-time restarted", g, 4'b0101);
        edges(4);                                // T'+28
        chk("R10 restart gap", g, 4'b0001);
        edges(1);                                // T'+29
        chk("R10 drive after restart", g, 4'b1001);

        // R11: disable drops gates within one edge
        edges(10);
        @(negedge clk) en = 1'b0;
        edges(1);
        chk("R11 gates low after disable", g, 4'b0000);
        trip = 1'b1;
        edges(3);
        @(negedge clk) en = 1'b1;
        wait_rise_ah();
        n = 0;
        do begin edges(1); n++; end while (gate_ah);
        chk("R11 fresh blanking after enable", n, BLANK);
        // R3: steady bursts with trip held
        wait_rise_ah();
        n = 0;
        do begin edges(1); n++; end while (gate_ah);
        chk("R3 on-time equals blank minus dead", n, BLANK - DEAD);
        do begin edges(1); n++; end while (!gate_ah);
        chk("R3 R4 cycle period", n, BLANK + 1 + OFF);
        @(negedge clk) trip = 1'b0;
        en = 1'b0;
        edges(2);

        chk("R8 no shoot-through seen", {31'd0, overlap_seen}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule